// File: doc/BRIEF.md
# Link Mode Controller for One Ethernet PHY Channel

This block holds the control state machine that decides how a single PHY channel runs. It settles the line speed (10 or 100 Mb/s) and the duplex, and it tracks whether the link is up. Automatic negotiation is switched on by two conditions together: a register enable bit and an external enable pin. When negotiation turns on, or a restart is requested, the channel goes quiet. It sends nothing, not even link pulses, for a long hold window. It then drops to the link-down state and negotiates again. The exchange of negotiation codewords and the priority resolution sit outside this block. Their outcome arrives here as a done strobe plus a resolved speed and duplex.

When negotiation is off, speed and duplex come from manual select bits. A link-disable control forces the link-up state at once and uses the manual selects. The transmitter keeps sending its normal keep-alive pattern in that state. An active-low LED output follows the link-up state. A transmit-mode output tells the line driver what to send: nothing, 10 Mb/s link pulses, or the 100 Mb/s idle pattern.

Top module: `link_mode_ctrl`

## Requirements
- R1: After synchronous reset the link state is link-down (code 1), the acknowledge and both detect bits are 0, the restart bit is 0 and the LED output is high.
- R2: Negotiation counts as active only while `cfg_an_en` and `pin_an_en` are both 1. The cycle after the two together go from inactive to active, the state is hold (code 0), unless link-disable is set.
- R3: Once entered, hold lasts exactly `HOLD_CYCLES` clock cycles and is followed by link-down. If negotiation goes inactive during hold, the next state is link-down. Throughout hold, `tx_halt` is 1 and `tx_mode` is 0 (silent).
- R4: A one-cycle pulse on `restart_set` makes `restart_bit` read 1 for the next cycle only. While negotiation is active, that bit sends the block to hold from any state on the following edge, and the hold window starts over.
- R5: While negotiation is inactive, `speed100` equals `man_speed100` and `full_dup` equals `man_full`. From link-down with `link_lost` low, the next state is link-up (code 3).
- R6: In negotiating (code 2), a `neg_done` pulse moves the block to link-up. The same edge stores `neg_speed100` and `neg_full` in `spd_det` and `dup_det` and sets `an_ack`. Entering hold clears `an_ack`. While negotiation is active and link-disable is low, `speed100` and `full_dup` show the detect bits.
- R7: While `link_dis` is 1, the next state is always link-up. This overrides enable edges and restarts, and speed and duplex come from the manual bits.
- R8: `link_led_n` is 0 exactly when the state is link-up.
- R9: Outside hold, `tx_mode` is 1 (link pulses) at 10 Mb/s and 2 (idle pattern) at 100 Mb/s.
- R10: In link-up, `link_lost` high moves the block to link-down unless link-disable is set. From link-down with negotiation active, the next state is negotiating.
- R11: If negotiation goes inactive while negotiating, the next state is link-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_an_en | input | 1 | Register enable for negotiation |
| pin_an_en | input | 1 | External enable pin for negotiation |
| restart_set | input | 1 | Write strobe that sets the self-clearing restart bit |
| link_dis | input | 1 | Forces link-up and manual mode |
| man_speed100 | input | 1 | Manual speed select, 1 = 100 Mb/s |
| man_full | input | 1 | Manual duplex select, 1 = full |
| neg_done | input | 1 | Negotiation engine finished |
| neg_speed100 | input | 1 | Resolved speed from the engine |
| neg_full | input | 1 | Resolved duplex from the engine |
| link_lost | input | 1 | Link integrity reports no valid link |
| speed100 | output | 1 | Operating speed, 1 = 100 Mb/s |
| full_dup | output | 1 | Operating duplex, 1 = full |
| tx_halt | output | 1 | All transmission stopped |
| tx_mode | output | 2 | 0 silent, 1 link pulses, 2 idle pattern |
| link_state | output | 2 | 0 hold, 1 link-down, 2 negotiating, 3 link-up |
| link_led_n | output | 1 | Active-low link indicator |
| an_ack | output | 1 | Negotiation finished acknowledge |
| spd_det | output | 1 | Stored negotiated speed |
| dup_det | output | 1 | Stored negotiated duplex |
| restart_bit | output | 1 | Self-clearing restart bit as it reads |

## Verification
The hardest case to reach is a restart that arrives while the hold window is already running. The stimulus must show that the window starts again from zero and does not simply run out at its first deadline. To get there, the bench uses a short hold window and raises both enables. It pulses the restart strobe part-way through hold, then again a few cycles later, and compares the exit cycle against a behavioural model. The bench also sets link-disable during hold and fires a restart under link-disable, to show that the forced link-up state wins over both.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_FAIL = 2'd1,
        ST_NEG  = 2'd2,
        ST_PASS = 2'd3
    } lmc_state_e;

    typedef enum logic [1:0] {
        TXM_SILENT = 2'd0,
        TXM_PULSE  = 2'd1,
        TXM_IDLE   = 2'd2
    } lmc_txm_e;

    typedef struct packed {
        logic speed100;
        logic full_dup;
    } lmc_mode_s;

    function automatic lmc_txm_e pick_txm(lmc_state_e st, logic s100);
        if (st == ST_HOLD) return TXM_SILENT;
        return s100 ? TXM_IDLE : TXM_PULSE;
    endfunction

endpackage

// File: rtl/lmc_hold_timer.sv
module lmc_hold_timer #(
    parameter int HOLD_CYCLES = 150_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(HOLD_CYCLES));

endmodule

// File: rtl/lmc_fsm.sv
module lmc_fsm
    import lmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       an_act,
    input  logic       act_rise,
    input  logic       restart_hit,
    input  logic       link_dis,
    input  logic       link_lost,
    input  logic       neg_done,
    input  lmc_mode_s  neg_mode,
    input  logic       hold_done,
    output lmc_state_e state,
    output logic       enter_hold,
    output logic       ack,
    output lmc_mode_s  det
);
    lmc_state_e nxt;
    logic       take;

    always_comb begin
        nxt        = state;
        enter_hold = 1'b0;
        take       = 1'b0;
        if (link_dis) begin
            nxt = ST_PASS;
        end else if (act_rise || restart_hit) begin
            nxt        = ST_HOLD;
            enter_hold = 1'b1;
        end else begin
            unique case (state)
                ST_HOLD: if (!an_act || hold_done) nxt = ST_FAIL;
                ST_FAIL: begin
                    if (an_act)          nxt = ST_NEG;
                    else if (!link_lost) nxt = ST_PASS;
                end
                ST_NEG: begin
                    if (!an_act) nxt = ST_FAIL;
                    else if (neg_done) begin
                        nxt  = ST_PASS;
                        take = 1'b1;
                    end
                end
                ST_PASS: if (link_lost) nxt = ST_FAIL;
                default: nxt = ST_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FAIL;
            ack   <= 1'b0;
            det   <= '0;
        end else begin
            state <= nxt;
            if (enter_hold) ack <= 1'b0;
            else if (take)  ack <= 1'b1;
            if (take) det <= neg_mode;
        end
    end

    assert_linkdis_pass_R7: assert property (@(posedge clk) disable iff (rst)
        link_dis |=> state == ST_PASS);

    assert_rise_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (act_rise && !link_dis) |=> state == ST_HOLD);

    assert_done_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NEG && neg_done && an_act && !link_dis && !act_rise && !restart_hit)
        |=> (state == ST_PASS && ack && det == $past(neg_mode)));

    assert_neg_abort_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NEG && !an_act && !link_dis) |=> state == ST_FAIL);

endmodule

// File: rtl/lmc_mode_resolve.sv
module lmc_mode_resolve
    import lmc_pkg::*;
(
    input  lmc_state_e state,
    input  logic       an_act,
    input  logic       link_dis,
    input  lmc_mode_s  man,
    input  lmc_mode_s  det,
    output lmc_mode_s  mode,
    output lmc_txm_e   txm,
    output logic       halt,
    output logic       led_n
);
    always_comb begin
        mode  = (an_act && !link_dis) ? det : man;
        txm   = pick_txm(state, mode.speed100);
        halt  = (state == ST_HOLD);
        led_n = (state != ST_PASS);
    end
endmodule

// File: rtl/link_mode_ctrl.sv
module link_mode_ctrl
    import lmc_pkg::*;
#(
    parameter int HOLD_CYCLES = 150_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_an_en,
    input  logic       pin_an_en,
    input  logic       restart_set,
    input  logic       link_dis,
    input  logic       man_speed100,
    input  logic       man_full,
    input  logic       neg_done,
    input  logic       neg_speed100,
    input  logic       neg_full,
    input  logic       link_lost,
    output logic       speed100,
    output logic       full_dup,
    output logic       tx_halt,
    output logic [1:0] tx_mode,
    output logic [1:0] link_state,
    output logic       link_led_n,
    output logic       an_ack,
    output logic       spd_det,
    output logic       dup_det,
    output logic       restart_bit
);
    logic       an_act, act_q, act_rise, restart_hit;
    logic       enter_hold, hold_done;
    lmc_state_e state;
    lmc_mode_s  det, mode, man_mode, neg_mode;
    lmc_txm_e   txm;

    assign an_act      = cfg_an_en && pin_an_en;
    assign act_rise    = an_act && !act_q;
    assign restart_hit = restart_bit && an_act;
    assign man_mode    = '{speed100: man_speed100, full_dup: man_full};
    assign neg_mode    = '{speed100: neg_speed100, full_dup: neg_full};

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q       <= 1'b0;
            restart_bit <= 1'b0;
        end else begin
            act_q       <= an_act;
            restart_bit <= restart_set;
        end
    end

    lmc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .an_act     (an_act),
        .act_rise   (act_rise),
        .restart_hit(restart_hit),
        .link_dis   (link_dis),
        .link_lost  (link_lost),
        .neg_done   (neg_done),
        .neg_mode   (neg_mode),
        .hold_done  (hold_done),
        .state      (state),
        .enter_hold (enter_hold),
        .ack        (an_ack),
        .det        (det)
    );

    lmc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clear(enter_hold),
        .run  (state == ST_HOLD),
        .done (hold_done)
    );

    lmc_mode_resolve u_resolve (
        .state   (state),
        .an_act  (an_act),
        .link_dis(link_dis),
        .man     (man_mode),
        .det     (det),
        .mode    (mode),
        .txm     (txm),
        .halt    (tx_halt),
        .led_n   (link_led_n)
    );

    assign speed100   = mode.speed100;
    assign full_dup   = mode.full_dup;
    assign tx_mode    = txm;
    assign link_state = state;
    assign spd_det    = det.speed100;
    assign dup_det    = det.full_dup;

    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (restart_bit && !restart_set) |=> !restart_bit);

    assert_restart_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (restart_hit && !link_dis) |=> link_state == 2'd0);

    assert_lost_fail_R10: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd3 && link_lost && !link_dis && !act_rise && !restart_hit)
        |=> link_state == 2'd1);

endmodule

// File: tb/link_mode_ctrl_tb_top.sv
module link_mode_ctrl_tb_top;
    localparam int HC = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_an_en = 0, pin_an_en = 0, restart_set = 0, link_dis = 0;
    logic man_speed100 = 0, man_full = 0, neg_done = 0, neg_speed100 = 0, neg_full = 0;
    logic link_lost = 1;
    logic speed100, full_dup, tx_halt, link_led_n, an_ack, spd_det, dup_det, restart_bit;
    logic [1:0] tx_mode, link_state;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_state, m_cnt;
    bit m_rbit, m_actq, m_ack, m_sd, m_dd;

    always #5 clk = ~clk;

    link_mode_ctrl #(.HOLD_CYCLES(HC)) dut_i (
        .clk(clk), .rst(rst), .cfg_an_en(cfg_an_en), .pin_an_en(pin_an_en),
        .restart_set(restart_set), .link_dis(link_dis), .man_speed100(man_speed100),
        .man_full(man_full), .neg_done(neg_done), .neg_speed100(neg_speed100),
        .neg_full(neg_full), .link_lost(link_lost), .speed100(speed100),
        .full_dup(full_dup), .tx_halt(tx_halt), .tx_mode(tx_mode),
        .link_state(link_state), .link_led_n(link_led_n), .an_ack(an_ack),
        .spd_det(spd_det), .dup_det(dup_det), .restart_bit(restart_bit)
    );

    always @(posedge clk) begin
        bit act, restart_go;
        int ns, nc;
        if (rst) begin
            m_state = 1; m_cnt = 0; m_rbit = 0; m_actq = 0; m_ack = 0; m_sd = 0; m_dd = 0;
        end else begin
            act = cfg_an_en && pin_an_en;
            restart_go = (act && !m_actq) || (m_rbit && act);
            ns = m_state; nc = 0;
            if (link_dis) ns = 3;
            else if (restart_go) begin ns = 0; m_ack = 0; end
            else if (m_state == 0) begin
                if (!act || m_cnt == HC - 1) ns = 1; else nc = m_cnt + 1;
            end else if (m_state == 1) begin
                if (act) ns = 2; else if (!link_lost) ns = 3;
            end else if (m_state == 2) begin
                if (!act) ns = 1;
                else if (neg_done) begin ns = 3; m_ack = 1; m_sd = neg_speed100; m_dd = neg_full; end
            end else if (link_lost) ns = 1;
            m_state = ns; m_cnt = nc;
            m_rbit = restart_set; m_actq = act;
        end
    end

    task automatic chk(string tag, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic compare();
        bit e_man, e_spd, e_dup;
        e_man = !(cfg_an_en && pin_an_en) || link_dis;
        e_spd = e_man ? man_speed100 : m_sd;
        e_dup = e_man ? man_full : m_dd;
        chk("R2 R3 R10 R11 link_state", link_state, m_state);
        chk("R3 tx_halt", tx_halt, m_state == 0);
        chk("R3 R9 tx_mode", tx_mode, (m_state == 0) ? 0 : (e_spd ? 2 : 1));
        chk("R5 R6 R7 speed100", speed100, e_spd);
        chk("R5 R6 R7 full_dup", full_dup, e_dup);
        chk("R8 link_led_n", link_led_n, m_state != 3);
        chk("R6 an_ack", an_ack, m_ack);
        chk("R6 spd_det", spd_det, m_sd);
        chk("R6 dup_det", dup_det, m_dd);
        chk("R4 restart_bit", restart_bit, m_rbit);
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            compare();
        end
    endtask

    task automatic pulse_restart();
        restart_set = 1; tick(1); restart_set = 0;
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state (one cycle out of reset, link still lost)
        chk("R1 reset state", link_state, 1);
        chk("R1 reset ack", an_ack, 0);
        chk("R1 reset led", link_led_n, 1);
        man_speed100 = 1; man_full = 0; tick(3);          // R5 manual, R9 idle
        link_lost = 0; tick(2);                           // R5 fail -> pass
        man_speed100 = 0; man_full = 1; tick(2);          // R9 pulses
        cfg_an_en = 1; tick(3);                           // R2 pin still low
        pin_an_en = 1; tick(5);                           // R2 hold
        tick(HC);                                         // R3 exit hold
        neg_speed100 = 1; neg_full = 1; tick(2);
        neg_done = 1; tick(1); neg_done = 0; tick(3);     // R6
        pulse_restart(); tick(5);                         // R4 restart from pass
        pulse_restart(); tick(4);                         // R4 restart mid-hold
        pulse_restart(); tick(HC + 3);
        pin_an_en = 0; tick(2);                           // R11 abort
        pin_an_en = 1; tick(4);
        link_dis = 1; tick(3);                            // R7 override hold
        pulse_restart(); tick(3);                         // R7 beats restart
        link_dis = 0; tick(3);
        link_lost = 1; tick(3);                           // R10
        link_lost = 0; neg_speed100 = 0; neg_full = 0;
        neg_done = 1; tick(1); neg_done = 0; tick(3);
        link_lost = 1; tick(3);
        link_dis = 1; tick(3);                            // R7 R10 stay pass
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule